// File: doc/BRIEF.md
# Multi-master SCL clock synchronizer

This block produces the serial clock for a master on a two-wire bus whose clock line is wired-AND. It drives the line only as an open-drain pull-down. Each clock period has a programmed low width and a programmed high width. The block watches the real level of the line so that it stays in step with any other master driving the same wire.

The high phase is timed only while the line actually reads high. If another device pulls the line low during the high phase, the block drops its high count at once and enters its own low phase. When its low count ends, the block releases the line. It does not start the high count until the line has really risen. The clock on the bus therefore takes the longest low time and the shortest high time of all the masters taking part.

A master-mode flag gates the whole function. Software sets the flag with a pulse. Hardware clears it when a stop condition is detected or when arbitration is lost. While the flag is clear, the block leaves the line alone. A one-cycle strobe marks each falling edge, so an external data shifter can advance on it.

Top module: `i2c_scl_sync`

## Requirements
- R1: After reset the line is released (`scl_drive_low`=0), `master_mode` is 0 and `period_done` is 0.
- R2: A `master_set` pulse sets `master_mode` from the next cycle on. A `stop_det` or `arb_lost` pulse clears it from the next cycle on. When a clear and a set arrive in the same cycle, the clear wins.
- R3: While `master_mode` is 0, the block never pulls the line low and never pulses `period_done`, whatever the bus does. A clear that arrives during a low phase releases the line in the next cycle.
- R4: Each low phase drives `scl_drive_low`=1 for exactly `low_width` cycles, whatever the bus does during it.
- R5: After the low phase the line is released. While the bus reads low, no high time is counted. With `scl_in` at 1 from the first released cycle, the released interval lasts the high width plus 3 cycles; a two-flop synchronizer and a one-cycle decision account for the 3. Each extra cycle that another device holds the line low lengthens the interval by one cycle.
- R6: If the bus stays high, the block pulls the line low again once its high width has elapsed.
- R7: If the synchronized bus level goes low during the high phase, the block starts its low phase on the following clock edge, 3 cycles after the low level reaches `scl_in`. The next low phase still lasts the full `low_width`.
- R8: `period_done` is high for exactly one cycle: the first cycle of every low phase, whether the block started that phase itself or followed the bus into it.
- R9: A programmed width of 0 behaves as a width of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw level read back from the bus clock line |
| master_set | input | 1 | Pulse requesting master operation |
| stop_det | input | 1 | Pulse: stop condition seen on the bus |
| arb_lost | input | 1 | Pulse: arbitration lost |
| low_width | input | CNT_W | Low-phase width in clock cycles (0 acts as 1) |
| high_width | input | CNT_W | High-phase width in clock cycles (0 acts as 1) |
| scl_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| master_mode | output | 1 | Master-mode flag |
| period_done | output | 1 | One-cycle strobe on each falling edge |

## Verification
The embedded assertions check these rules on every cycle:
- the flag is cleared and set with clear priority;
- the line stays released in slave mode;
- the strobe appears only in the first cycle of a low phase;
- no high time is counted while the synchronized line is low;
- the block jumps into its low phase after a low is seen during the high phase.

Exact widths can only be shown by the bench scenarios. These cover the low width, the released interval of high width plus synchronizer latency, the stretching by another master, the abort point and the treatment of zero widths. The bench measures them at the pins against a wired-AND bus model, using both random and directed counts.

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             master_set,
  input  logic             stop_det,
  input  logic             arb_lost,
  input  logic [CNT_W-1:0] low_width,
  input  logic [CNT_W-1:0] high_width,
  output logic             scl_drive_low,
  output logic             master_mode,
  output logic             period_done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {PH_WAIT = 2'd0, PH_HIGH = 2'd1, PH_LOW = 2'd2} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sync_q;
  logic             master_q;
  logic             strobe_q;
  logic             master_nxt;
  logic [CNT_W-1:0] low_lim;
  logic [CNT_W-1:0] high_lim;

  assign master_nxt = (stop_det || arb_lost) ? 1'b0 : (master_set ? 1'b1 : master_q);
  assign low_lim    = (low_width  == '0) ? '0 : low_width  - ONE;
  assign high_lim   = (high_width == '0) ? '0 : high_width - ONE;

  assign scl_drive_low = (phase == PH_LOW);
  assign master_mode   = master_q;
  assign period_done   = strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 2'b00;
      master_q <= 1'b0;
      phase    <= PH_WAIT;
      cnt      <= '0;
      strobe_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], scl_in};
      master_q <= master_nxt;
      strobe_q <= 1'b0;
      if (!master_nxt) begin
        phase <= PH_WAIT;
        cnt   <= '0;
      end else begin
        case (phase)
          PH_LOW: begin
            if (cnt == low_lim) begin
              phase <= PH_WAIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          PH_WAIT: begin
            if (&sync_q) begin
              phase <= PH_HIGH;
              cnt   <= '0;
            end
          end
          PH_HIGH: begin
            if (!sync_q[1] || cnt == high_lim) begin
              phase    <= PH_LOW;
              cnt      <= '0;
              strobe_q <= 1'b1;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          default: begin
            phase <= PH_WAIT;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || arb_lost) |=> !master_mode);

  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    (master_set && !stop_det && !arb_lost) |=> master_mode);

  a_r3_slave_released: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!scl_drive_low && !period_done));

  a_r5_no_high_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !sync_q[1]) |=> (phase != PH_HIGH));

  a_r7_follow_bus_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !sync_q[1] && master_nxt) |=> (scl_drive_low && cnt == '0));

  a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> period_done);

  a_r8_strobe_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (scl_drive_low && !$past(scl_drive_low)));

endmodule

// File: tb/test_i2c_scl_sync.sv
module test_i2c_scl_sync;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             other_low = 1'b0;
  logic             master_set = 1'b0;
  logic             stop_det = 1'b0;
  logic             arb_lost = 1'b0;
  logic [CNT_W-1:0] low_w = 8'd4;
  logic [CNT_W-1:0] high_w = 8'd5;
  logic             scl_drive_low;
  logic             master_mode;
  logic             period_done;
  logic             scl_in;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign scl_in = !(scl_drive_low || other_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_sync #(.CNT_W(CNT_W)) i_i2c_scl_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .master_set(master_set),
    .stop_det(stop_det), .arb_lost(arb_lost), .low_width(low_w),
    .high_width(high_w), .scl_drive_low(scl_drive_low),
    .master_mode(master_mode), .period_done(period_done)
  );

  function automatic int eff(input logic [CNT_W-1:0] w);
    return (w == '0) ? 1 : int'(w);
  endfunction

  function automatic int exp_released(input logic [CNT_W-1:0] hw, input int stretch);
    return eff(hw) + 3 + stretch;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_fall();
    int n = 0;
    while (!scl_drive_low && n < 2000) begin n++; tick(); end
    chk(scl_drive_low, "R6", scl_drive_low, 1);
  endtask

  task automatic run_period(input int stretch);
    int n = 0;
    int m = 0;
    chk(period_done == 1'b1, "R8", period_done, 1);
    while (scl_drive_low && n < 1000) begin
      if (n > 0 && period_done) chk(1'b0, "R8", 1, 0);
      n++;
      tick();
    end
    chk(n == eff(low_w), (low_w == '0) ? "R9" : "R4", n, eff(low_w));
    while (!scl_drive_low && m < 2000) begin
      if (m == 0) other_low = (stretch > 0);
      if (m == stretch) other_low = 1'b0;
      if (period_done) chk(1'b0, "R8", 1, 0);
      m++;
      tick();
    end
    chk(m == exp_released(high_w, stretch),
        (high_w == '0) ? "R9" : ((stretch > 0) ? "R5" : "R6"),
        m, exp_released(high_w, stretch));
  endtask

  task automatic pulse_stop();
    stop_det = 1'b1; tick(); stop_det = 1'b0;
  endtask

  task automatic pulse_set();
    master_set = 1'b1; tick(); master_set = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!scl_drive_low, "R1", scl_drive_low, 0);
    chk(!master_mode, "R1", master_mode, 0);
    chk(!period_done, "R1", period_done, 0);

    // R3 slave mode ignores bus activity
    for (int i = 0; i < 20; i++) begin
      other_low = $urandom % 2;
      tick();
      chk(!scl_drive_low && !period_done, "R3", scl_drive_low, 0);
    end
    other_low = 1'b0;
    repeat (3) tick();

    // R2 set
    pulse_set();
    chk(master_mode, "R2", master_mode, 1);
    wait_fall();
    run_period(0);
    run_period(2);
    run_period(0);

    // R3 clear during low phase via stop
    chk(scl_drive_low, "R3", scl_drive_low, 1);
    pulse_stop();
    chk(!master_mode, "R2", master_mode, 0);
    chk(!scl_drive_low, "R3", scl_drive_low, 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(!scl_drive_low && !period_done, "R3", scl_drive_low, 0);
    end

    // R2 clear wins over simultaneous set
    master_set = 1'b1; arb_lost = 1'b1; tick();
    master_set = 1'b0; arb_lost = 1'b0;
    chk(!master_mode, "R2", master_mode, 0);

    // R2 arbitration loss clears master mode
    pulse_set();
    chk(master_mode, "R2", master_mode, 1);
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
    chk(!master_mode, "R2", master_mode, 0);
    chk(!scl_drive_low, "R3", scl_drive_low, 0);

    // R7 abort of the high phase by another master
    low_w = 8'd8; high_w = 8'd40;
    repeat (3) tick();
    pulse_set();
    wait_fall();
    begin
      int n = 0;
      int m = 0;
      while (scl_drive_low && n < 1000) begin n++; tick(); end
      chk(n == 8, "R4", n, 8);
      while (m < 6) begin m++; tick(); end
      other_low = 1'b1;
      m = 0;
      while (!scl_drive_low && m < 100) begin m++; tick(); end
      chk(m == 3, "R7", m, 3);
      chk(period_done, "R8", period_done, 1);
      n = 0;
      while (scl_drive_low && n < 1000) begin
        if (n == 4) other_low = 1'b0;
        n++;
        tick();
      end
      chk(n == 8, "R7", n, 8);
      m = 0;
      while (!scl_drive_low && m < 1000) begin m++; tick(); end
      chk(m == exp_released(high_w, 0), "R6", m, exp_released(high_w, 0));
    end
    other_low = 1'b0;

    // R9 zero widths directed
    pulse_stop();
    low_w = 8'd0; high_w = 8'd0;
    pulse_set();
    wait_fall();
    run_period(0);
    run_period(1);

    // random widths and stretches
    for (int t = 0; t < 12; t++) begin
      pulse_stop();
      low_w = CNT_W'($urandom % 13);
      high_w = CNT_W'($urandom % 13);
      pulse_set();
      wait_fall();
      for (int p = 0; p < 3; p++) run_period(($urandom % 2) ? int'($urandom % 6) : 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule